// File: doc/BRIEF.md
# Periodic Wakeup Interrupt Timer

This block raises a periodic interrupt. Software sets a 16-bit reload value and an 8-bit control register over a small synchronous register bus, picks a timer source, and turns the timer on. While the timer runs, a down-counter counts ticks of the chosen source. Each time it passes zero it reloads and sets a sticky timeout flag. The flag drives the interrupt line when the interrupt enable is set. Software clears the flag by writing a one to the flag bit.

There are two tick sources. One is an external single-cycle strobe that comes from a slow free-running clock. The other is the bus clock, which ticks on every cycle. Both are handled inside the one clock domain of the block. The source select is locked while the timer runs, so software cannot switch the source under a running count.

Top module: `wake_timer`

## Requirements
- R1: After reset, every readable register returns 0x00 and `irq` is low.
- R2: Control bit 7 selects the source. A value of 0 counts only cycles in which `autoTick` is high. A value of 1 counts every clock cycle.
- R3: Bit 7 takes a written value only when bit 2 was 0 before the write and the written bit 2 is also 0. Any other write leaves bit 7 unchanged.
- R4: Bit 2 set to 1 starts the timer from the reload value. With reload value N, bit 0 rises after N+1 source ticks, and again every N+1 ticks after that.
- R5: Bit 2 cleared to 0 stops the count and holds the counter at the reload value. A set flag stays set, and ticks change nothing while the timer is stopped.
- R6: Writing 1 to bit 0 of the control register clears the flag. Writing 0 to it leaves the flag unchanged.
- R7: When a clear write and a timeout fall in the same cycle, the flag is 0 afterwards.
- R8: `irq` is high exactly when bit 0 and bit 1 (interrupt enable) are both 1.
- R9: Control bits 6 to 3 always read 0 and ignore writes. Address 3 reads 0.
- R10: Address 1 holds reload bits 7:0 and address 2 holds bits 15:8, both read/write. A reload value written while the timer is stopped is used on the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the bus-clock tick source |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regAddr | input | 2 | Register address: 0 control, 1 reload low, 2 reload high |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr`, combinational |
| autoTick | input | 1 | Single-cycle tick strobe from the free-running source |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the embedded assertions check several properties: the source select stays frozen while the timer runs, a clear write always leaves the flag low, a set flag stays set unless it is cleared, the counter stays still when there is no tick, and each expiry reloads the counter. Only the bench scenarios can show the things that need a long history. These include the exact N+1 tick spacing under both sources, the select being refused on the same write that enables the timer, the clear landing exactly on an expiry edge, and a new reload value being picked up after a restart. A behavioural model in the bench checks read data and `irq` against the design on every cycle.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned SEL_BIT   = 7;
  localparam int unsigned EN_BIT    = 2;
  localparam int unsigned IE_BIT    = 1;
  localparam int unsigned FLAG_BIT  = 0;
  localparam int unsigned CTRL_ADDR = 0;

  typedef struct packed {
    logic run;     // timer enabled
    logic tickEn;  // selected source ticks this cycle
  } wktStrobes_t;
endpackage

// File: rtl/wkt_ctrl.sv
module wkt_ctrl
  import wkt_pkg::*;
#(
  parameter int unsigned PERIOD_W = 16,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWdata,
  input  logic                autoTick,
  input  logic                expire,
  output wktStrobes_t         strobes,
  output logic [PERIOD_W-1:0] reloadVal,
  output logic [REG_W-1:0]    regRdata,
  output logic                irq
);
  localparam int unsigned NUM_BYTES = PERIOD_W / REG_W;

  logic clkSel, featEn, intEn, flag;
  logic wrCtrl, clearReq;
  logic [PERIOD_W-1:0] period;
  logic unusedRsvd;

  assign unusedRsvd = ^regWdata[SEL_BIT-1:EN_BIT+1];
  assign wrCtrl   = regWrEn && (regAddr == ADDR_W'(CTRL_ADDR));
  assign clearReq = wrCtrl && regWdata[FLAG_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel <= 1'b0;
      featEn <= 1'b0;
      intEn  <= 1'b0;
    end else if (wrCtrl) begin
      if (!featEn && !regWdata[EN_BIT]) clkSel <= regWdata[SEL_BIT];
      featEn <= regWdata[EN_BIT];
      intEn  <= regWdata[IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         flag <= 1'b0;
    else if (clearReq) flag <= 1'b0;
    else if (expire)   flag <= 1'b1;
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_perByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        period[b*REG_W +: REG_W] <= '0;
      else if (regWrEn && (regAddr == ADDR_W'(b + 1)))
        period[b*REG_W +: REG_W] <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(CTRL_ADDR)) begin
      regRdata[SEL_BIT]  = clkSel;
      regRdata[EN_BIT]   = featEn;
      regRdata[IE_BIT]   = intEn;
      regRdata[FLAG_BIT] = flag;
    end
    for (int b = 0; b < NUM_BYTES; b++)
      if (regAddr == ADDR_W'(b + 1)) regRdata = period[b*REG_W +: REG_W];
  end

  assign strobes.run    = featEn;
  assign strobes.tickEn = featEn && (clkSel || autoTick);
  assign reloadVal      = period;
  assign irq            = flag && intEn;

  AST_CLKSEL_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    featEn |=> $stable(clkSel)); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> !flag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !clearReq) |=> flag); // R5
endmodule

// File: rtl/wkt_datapath.sv
module wkt_datapath
  import wkt_pkg::*;
#(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  wktStrobes_t         strobes,
  input  logic [PERIOD_W-1:0] reloadVal,
  output logic                expire
);
  logic [PERIOD_W-1:0] cnt;
  logic atZero;

  assign atZero = (cnt == '0);
  assign expire = strobes.run && strobes.tickEn && atZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (!strobes.run)   cnt <= reloadVal;
    else if (strobes.tickEn) cnt <= atZero ? reloadVal : cnt - PERIOD_W'(1);
  end

  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && !strobes.tickEn) |=> (cnt == $past(cnt))); // R2
  AST_EXPIRE_RELOADS: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (cnt == $past(reloadVal))); // R4
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wkt_pkg::*;
#(
  parameter int unsigned PERIOD_W = 16,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              autoTick,
  output logic              irq
);
  wktStrobes_t         strobes;
  logic [PERIOD_W-1:0] reloadVal;
  logic                expire;

  wkt_ctrl #(.PERIOD_W(PERIOD_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .autoTick(autoTick), .expire(expire),
    .strobes(strobes), .reloadVal(reloadVal), .regRdata(regRdata), .irq(irq)
  );

  wkt_datapath #(.PERIOD_W(PERIOD_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reloadVal(reloadVal),
    .expire(expire)
  );
endmodule

// File: tb/test_wake_timer.sv
`timescale 1ns/100ps
module test_wake_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic autoTick = 1'b0;
  logic [7:0] regRdata;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wake_timer i_wake_timer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .autoTick(autoTick), .irq(irq)
  );

  // behavioural reference
  bit mSel, mEn, mIe, mFlag;
  int mPeriod, mCnt;

  always @(posedge clk) begin
    bit tick, exp;
    int nCnt;
    if (!rstN) begin
      mSel = 0; mEn = 0; mIe = 0; mFlag = 0; mPeriod = 0; mCnt = 0;
    end else begin
      tick = mEn && (mSel || autoTick);
      exp  = tick && (mCnt == 0);
      if (!mEn) nCnt = mPeriod;
      else if (tick) nCnt = (mCnt == 0) ? mPeriod : mCnt - 1;
      else nCnt = mCnt;
      if (exp) mFlag = 1;
      if (regWrEn) begin
        case (regAddr)
          2'd0: begin
            if (!mEn && !regWdata[2]) mSel = regWdata[7];
            mEn = regWdata[2];
            mIe = regWdata[1];
            if (regWdata[0]) mFlag = 0;
          end
          2'd1: mPeriod = (mPeriod & 32'hFF00) | regWdata;
          2'd2: mPeriod = (mPeriod & 32'h00FF) | (int'(regWdata) << 8);
          default: ;
        endcase
      end
      mCnt = nCnt;
    end
  end

  function automatic logic [7:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0: return {mSel, 4'b0000, mEn, mIe, mFlag};
      2'd1: return mPeriod[7:0];
      2'd2: return mPeriod[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R8 irq per cycle", {7'd0, irq}, {7'd0, mFlag && mIe});
      check("R6 readback per cycle", regRdata, modelRead(regAddr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWrEn = 0; regWdata = 8'h00;
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [7:0] mask,
                       input logic [7:0] exp, input string req);
    regAddr = a; #0.5;
    check(req, regRdata & mask, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      autoTick = 1; @(posedge clk); #1; autoTick = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    rdChk(2'd0, 8'hFF, 8'h00, "R1 ctrl reset");
    check("R1 irq reset", {7'd0, irq}, 8'h00);
    idle(3);
    rstN = 1;
    @(posedge clk); #1;
    rdChk(2'd1, 8'hFF, 8'h00, "R1 reload low reset");
    rdChk(2'd2, 8'hFF, 8'h00, "R1 reload high reset");
    // bus clock, reload 3
    wr(2'd1, 8'h03);
    rdChk(2'd1, 8'hFF, 8'h03, "R10 reload low");
    wr(2'd0, 8'h80);
    rdChk(2'd0, 8'hFF, 8'h80, "R2 select bus clock");
    wr(2'd0, 8'h86);
    idle(3);
    rdChk(2'd0, 8'h01, 8'h00, "R4 no flag before N+1 ticks");
    idle(1);
    rdChk(2'd0, 8'h01, 8'h01, "R4 flag after N+1 ticks");
    check("R8 irq with flag and enable", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h86);
    rdChk(2'd0, 8'h01, 8'h01, "R6 write 0 keeps flag");
    wr(2'd0, 8'h87);
    rdChk(2'd0, 8'h01, 8'h00, "R6 write 1 clears flag");
    // clear coinciding with expiry: reload 0 expires every cycle
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h86);
    wr(2'd0, 8'h87);
    rdChk(2'd0, 8'hFF, 8'h86, "R7 clear beats set");
    idle(1);
    rdChk(2'd0, 8'hFF, 8'h87, "R7 set again next expiry");
    // lock
    wr(2'd0, 8'h06);
    rdChk(2'd0, 8'h80, 8'h80, "R3 select locked while running");
    wr(2'd0, 8'h01);
    rdChk(2'd0, 8'hFF, 8'h80, "R3 select kept on disabling write");
    wr(2'd0, 8'h00);
    rdChk(2'd0, 8'hFF, 8'h00, "R3 select written while stopped");
    // auto source, reload 2
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h84);
    rdChk(2'd0, 8'hFF, 8'h04, "R3 select ignored on enabling write");
    pulse(2);
    rdChk(2'd0, 8'h01, 8'h00, "R2 two auto ticks no flag");
    pulse(1);
    rdChk(2'd0, 8'h01, 8'h01, "R4 third auto tick sets flag");
    wr(2'd0, 8'h05);
    idle(10);
    rdChk(2'd0, 8'h01, 8'h00, "R2 auto source ignores bus cycles");
    pulse(3);
    rdChk(2'd0, 8'h01, 8'h01, "R4 repeat period auto");
    // disable
    wr(2'd0, 8'h00);
    rdChk(2'd0, 8'hFF, 8'h01, "R5 flag kept on disable");
    wr(2'd0, 8'h01);
    pulse(5);
    rdChk(2'd0, 8'hFF, 8'h00, "R5 stopped timer ignores ticks");
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h00);
    rdChk(2'd1, 8'hFF, 8'h01, "R10 new reload value");
    wr(2'd0, 8'h04);
    pulse(1);
    rdChk(2'd0, 8'h01, 8'h00, "R10 one tick not enough");
    pulse(1);
    rdChk(2'd0, 8'hFF, 8'h05, "R10 new reload used on restart");
    // reserved bits
    wr(2'd0, 8'h79);
    rdChk(2'd0, 8'hFF, 8'h00, "R9 reserved bits read zero");
    wr(2'd2, 8'hA5);
    rdChk(2'd2, 8'hFF, 8'hA5, "R10 reload high");
    rdChk(2'd3, 8'hFF, 8'h00, "R9 address 3 reads zero");
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule